// File: doc/BRIEF.md
# EEPROM Page Write Buffer with Guarded Commit

This block sits between the byte-level front end of a two-wire serial EEPROM slave and its storage array. The front end reports each bus event as a one-cycle strobe: a START condition, the completed 16-bit word address (after the second address byte), each acknowledged data byte, and a STOP condition. The block collects the data bytes of a byte or page write in a page-sized holding buffer. Nothing reaches the array until STOP arrives.

On a STOP that follows at least one buffered byte, the block enters a self-timed programming phase. The phase lasts a fixed number of system clock cycles. While it runs, `busy` is high and every strobe from the front end is ignored. During the first cycles of the phase, the buffer is streamed into the array through a simple write port, one slot per cycle.

A write-control input guards the upper quarter of the array. If that input is seen high at any point between START and the address strobe, the committed page is dropped whenever it lies in the upper quarter. The bytes are still taken in and the timed cycle still runs. Pages lower in the array are written as normal.

Top module: `eeprom_page_writer`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `busy` and `mem_we` are low.
- R2: The n-th data byte (counting from 0) after the address strobe goes to page slot `(A mod PAGE_BYTES + n) mod PAGE_BYTES`, where A is the strobed address. A byte past the page size therefore overwrites the earliest slot. At commit, slot s is written to address `{A[ADDR_W-1:5], s}`.
- R3: A commit starts only on a STOP that follows at least one data byte of the current command. A STOP with no data byte leaves `busy` low and produces no array write.
- R4: After a STOP that starts a commit, `busy` rises on the next cycle and stays high for exactly PROG_CYCLES cycles.
- R5: In busy cycle i (counting from 0), `mem_we` is high only if i < PAGE_BYTES and slot i holds a byte. In that cycle `mem_wdata` is the last byte buffered in slot i.
- R6: If `wc_in` is high in any cycle from the START strobe up to and including the address strobe, no write reaches an upper-quarter address for that command. `busy` still runs for its full length.
- R7: If `wc_in` is low for the whole of that window, every location can be written. The level of `wc_in` after the address strobe has no effect.
- R8: The upper quarter consists of the addresses whose two most significant bits (bits ADDR_W-1 and ADDR_W-2) are both 1. For ADDR_W=13 this is 0x1800 to 0x1FFF.
- R9: While `busy` is high, START, address, data and STOP strobes are ignored and do not start a later commit.
- R10: A START after buffered data and before STOP discards the buffer. Only bytes taken in after the new address strobe are committed.
- R11: Data strobes that arrive between START and the address strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_in | input | 1 | START condition seen on the bus (one-cycle strobe) |
| addr_valid | input | 1 | Second address byte complete; `addr_in` is valid |
| addr_in | input | ADDR_W | Word address, with the don't-care upper bits already removed |
| data_valid | input | 1 | Acknowledged data byte available on `data_in` |
| data_in | input | 8 | Data byte |
| stop_in | input | 1 | STOP condition seen on the bus (one-cycle strobe) |
| wc_in | input | 1 | Write-control level; high protects the upper quarter |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Programming cycle in progress; front end must stay deaf |

## Verification
The bench aims at page wrap-around in two ways. A page started near its end must fold back to slot 0, and a 34-byte burst must leave the last two bytes in the first two slots. A design that counts linearly would write into the next page or keep the stale bytes. Write control is raised in only one cycle of the guarded window at a time (the START cycle alone, the address cycle alone), and separately only after the window has closed. A guard that samples a single point would then either let a protected page through or block an unprotected one. Addresses just below and inside the upper quarter check the boundary decode. STOP with no data, a repeated START over buffered bytes, early data strobes and strobes sent during `busy` check that a spurious or extra programming cycle is never started.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } cmd_state_e;

    // Upper quarter of the array: both address MSBs set.
    function automatic logic in_top_quarter(input logic [1:0] msbs);
        return msbs[1] & msbs[0];
    endfunction

endpackage

// File: rtl/pwb_page_store.sv
module pwb_page_store
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_slot,
    input  byte_t            wr_data,
    input  logic [OFF_W-1:0] rd_slot,
    output byte_t            rd_data,
    output logic             rd_valid,
    output logic             any_valid
);

    byte_t                 slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        localparam logic [OFF_W-1:0] IDX = OFF_W'(g);
        logic hit;
        assign hit = wr_en && (wr_slot == IDX);

        always_ff @(posedge clk) begin
            if (hit) slot_q[g] <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst || clear) vld_q[g] <= 1'b0;
            else if (hit)     vld_q[g] <= 1'b1;
        end
    end

    assign rd_data   = slot_q[rd_slot];
    assign rd_valid  = vld_q[rd_slot];
    assign any_valid = |vld_q;

    // R10
    no_clear_write_chk: assert property (@(posedge clk) disable iff (rst)
        clear |-> !wr_en);

endmodule

// File: rtl/pwb_wc_guard.sv
module pwb_wc_guard (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic track,
    input  logic wc,
    output logic prot
);

    logic prot_q;

    always_ff @(posedge clk) begin
        if (rst)        prot_q <= 1'b0;
        else if (arm)   prot_q <= wc;
        else if (track) prot_q <= prot_q | wc;
    end

    assign prot = prot_q;

    // R6
    sticky_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (track && wc) |=> prot);

endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
    parameter int PROG_CYCLES = 200,
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    output logic             busy,
    output logic [CNT_W-1:0] tick
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) busy_q <= 1'b0;
            else               cnt_q  <= cnt_q + 1'b1;
        end else if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end
    end

    assign busy = busy_q;
    assign tick = cnt_q;

    // R4
    full_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_in,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_valid,
    input  logic [7:0]        data_in,
    input  logic              stop_in,
    input  logic              wc_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    cmd_state_e        state_q;
    logic [ADDR_W-1:0] base_q;
    logic [OFF_W-1:0]  nbytes_q;

    logic             busy_w;
    logic [CNT_W-1:0] tick_w;
    logic             prot_w;
    logic             any_w;
    logic             rd_vld_w;
    byte_t            rd_data_w;

    logic             accept_start;
    logic             store_wr;
    logic             launch;
    logic [OFF_W-1:0] wr_slot;
    logic [OFF_W-1:0] rd_slot;
    logic             page_locked;
    logic             in_window;

    assign accept_start = !busy_w && start_in;
    assign store_wr     = !busy_w && (state_q == ST_DATA) && !start_in && data_valid;
    assign launch       = !busy_w && (state_q == ST_DATA) && !start_in && !data_valid
                          && stop_in && any_w;
    assign wr_slot      = base_q[OFF_W-1:0] + nbytes_q;
    assign rd_slot      = tick_w[OFF_W-1:0];
    assign in_window    = !busy_w && (state_q == ST_ADDR) && !start_in;
    assign page_locked  = prot_w && in_top_quarter(base_q[ADDR_W-1 -: 2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            base_q   <= '0;
            nbytes_q <= '0;
        end else if (!busy_w) begin
            if (start_in) begin
                state_q  <= ST_ADDR;
                nbytes_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR: begin
                        if (addr_valid) begin
                            base_q  <= addr_in;
                            state_q <= ST_DATA;
                        end else if (stop_in) begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_DATA: begin
                        if (data_valid)   nbytes_q <= nbytes_q + 1'b1;
                        else if (stop_in) state_q  <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    pwb_page_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept_start),
        .wr_en     (store_wr),
        .wr_slot   (wr_slot),
        .wr_data   (data_in),
        .rd_slot   (rd_slot),
        .rd_data   (rd_data_w),
        .rd_valid  (rd_vld_w),
        .any_valid (any_w)
    );

    pwb_wc_guard u_guard (
        .clk   (clk),
        .rst   (rst),
        .arm   (accept_start),
        .track (in_window),
        .wc    (wc_in),
        .prot  (prot_w)
    );

    pwb_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .launch (launch),
        .busy   (busy_w),
        .tick   (tick_w)
    );

    assign busy      = busy_w;
    assign mem_we    = busy_w && (32'(tick_w) < PAGE_BYTES) && rd_vld_w && !page_locked;
    assign mem_addr  = {base_q[ADDR_W-1:OFF_W], rd_slot};
    assign mem_wdata = rd_data_w;

    // R5
    write_in_prog_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R6
    protect_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && prot_w) |-> !in_top_quarter(mem_addr[ADDR_W-1 -: 2]));

    // R3
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_in));

    // R9
    deaf_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (state_q == ST_IDLE));

endmodule

// File: tb/tb_eeprom_page_writer.sv
module tb_eeprom_page_writer;

    localparam int AW   = 13;
    localparam int PG   = 32;
    localparam int PROG = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_in = 1'b0, addr_valid = 1'b0, data_valid = 1'b0;
    logic          stop_in = 1'b0, wc_in = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0]    data_in = '0;
    logic          mem_we, busy;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    always #2.5 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(AW), .PAGE_BYTES(PG), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst(rst), .start_in(start_in), .addr_valid(addr_valid),
        .addr_in(addr_in), .data_valid(data_valid), .data_in(data_in),
        .stop_in(stop_in), .wc_in(wc_in), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy)
    );

    int    checks = 0, fails = 0, cyc = 0;
    int    sc_writes = 0, sc_busy = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural reference state
    int   m_phase = 0, m_base = 0, m_n = 0, m_tick = 0;
    bit   m_busy = 0, m_prot = 0;
    int   m_slot [PG];
    bit   m_vld  [PG];

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_busy = 0; m_prot = 0; m_n = 0; m_tick = 0;
            for (int i = 0; i < PG; i++) m_vld[i] = 0;
        end else if (m_busy) begin
            m_tick++;
            if (m_tick == PROG) m_busy = 0;
        end else if (start_in) begin
            m_phase = 1; m_prot = wc_in; m_n = 0;
            for (int i = 0; i < PG; i++) m_vld[i] = 0;
        end else if (m_phase == 1) begin
            m_prot = m_prot | wc_in;
            if (addr_valid) begin m_base = int'(addr_in); m_phase = 2; end
            else if (stop_in) m_phase = 0;
        end else if (m_phase == 2) begin
            if (data_valid) begin
                int s;
                s = ((m_base % PG) + m_n) % PG;
                m_slot[s] = int'(data_in); m_vld[s] = 1; m_n++;
            end else if (stop_in) begin
                bit any;
                any = 0;
                for (int i = 0; i < PG; i++) any |= m_vld[i];
                if (any) begin m_busy = 1; m_tick = 0; end
                m_phase = 0;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_we;
            bit locked;
            locked = m_prot && ((m_base >> (AW - 2)) == 3);
            e_we = m_busy && (m_tick < PG) && m_vld[m_tick % PG] && !locked;
            check(cur_req, "busy", int'(busy), int'(m_busy));
            check(cur_req, "mem_we", int'(mem_we), int'(e_we));
            if (e_we) begin
                check(cur_req, "mem_addr", int'(mem_addr), ((m_base / PG) * PG) + m_tick);
                check(cur_req, "mem_wdata", int'(mem_wdata), m_slot[m_tick]);
            end
            if (mem_we) sc_writes++;
            if (busy)   sc_busy++;
        end
    end

    task automatic step(); @(negedge clk); endtask
    task automatic clr();
        start_in = 0; addr_valid = 0; data_valid = 0; stop_in = 0;
    endtask
    task automatic send_start(bit w); step(); clr(); wc_in = w; start_in = 1; step(); clr(); endtask
    task automatic send_addr(int a, bit w);
        wc_in = w; addr_in = AW'(a); addr_valid = 1; step(); clr();
    endtask
    task automatic send_data(int d); data_in = 8'(d); data_valid = 1; step(); clr(); endtask
    task automatic send_stop(); stop_in = 1; step(); clr(); endtask
    task automatic begin_sc(string r); cur_req = r; sc_writes = 0; sc_busy = 0; endtask
    task automatic end_sc(int exp_w, int exp_b);
        repeat (PROG + 6) step();
        check(cur_req, "write count", sc_writes, exp_w);
        check(cur_req, "busy length", sc_busy, exp_b);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1; fails++;
            $display("FAIL watchdog actual %0d expected <100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "mem_we in reset", int'(mem_we), 0);
        rst = 0;
        @(negedge clk);
        check("R1", "busy after reset", int'(busy), 0);

        // R5 byte write
        begin_sc("R5");
        send_start(0); send_addr('h0105, 0); send_data('hA5); send_stop();
        end_sc(1, PROG);

        // R2 page folding from offset 30
        begin_sc("R2");
        send_start(0); send_addr('h005E, 0);
        for (int i = 0; i < 4; i++) send_data('h10 + i);
        send_stop();
        end_sc(4, PROG);

        // R2 34 bytes overwrite first two slots
        begin_sc("R2");
        send_start(0); send_addr('h0200, 0);
        for (int i = 0; i < 34; i++) send_data('h40 + i);
        send_stop();
        end_sc(32, PROG);

        // R6 wc high only at START
        begin_sc("R6");
        send_start(1); wc_in = 0; send_addr('h1820, 0);
        for (int i = 0; i < 3; i++) send_data(i);
        send_stop();
        end_sc(0, PROG);

        // R6 wc high only at address strobe
        begin_sc("R6");
        send_start(0); send_addr('h1FF0, 1); wc_in = 0;
        send_data('h77); send_stop();
        end_sc(0, PROG);

        // R7 wc high only after the address
        begin_sc("R7");
        send_start(0); send_addr('h1FE0, 0); wc_in = 1;
        send_data('h01); send_data('h02); send_stop(); wc_in = 0;
        end_sc(2, PROG);

        // R8 just below the upper quarter, guard raised
        begin_sc("R8");
        send_start(1); send_addr('h17E0, 1);
        send_data('h33); send_data('h44); send_stop(); wc_in = 0;
        end_sc(2, PROG);

        // R3 STOP with no data
        begin_sc("R3");
        send_start(0); send_addr('h0010, 0); send_stop();
        end_sc(0, 0);

        // R10 repeated START discards buffer
        begin_sc("R10");
        send_start(0); send_addr('h0100, 0);
        send_data('hDE); send_data('hAD); send_data('hBE);
        send_start(0); send_addr('h0300, 0); send_data('h5A); send_stop();
        end_sc(1, PROG);

        // R9 strobes during busy are ignored
        begin_sc("R9");
        send_start(0); send_addr('h0400, 0); send_data('h11); send_stop();
        repeat (3) step();
        send_start(0); send_addr('h0500, 0); send_data('h22); send_stop();
        end_sc(1, PROG);

        // R11 data before address ignored
        begin_sc("R11");
        send_start(0); send_data('h99); send_addr('h0600, 0); send_data('h66); send_stop();
        end_sc(1, PROG);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule